// File: doc/BRIEF.md
# Battery-Backed SRAM Cartridge with Mode-0 Parallel Port Controller

This block models the cartridge side of a small non-volatile storage peripheral. A host with an 8-bit I/O bus reaches four consecutive I/O ports, by default 0xB0 to 0xB3. Behind them sits a reduced mode-0 parallel port controller: two output latches that form the memory address and the strobes, one data latch whose direction can be switched, and a control register. The latches drive two 2048-byte static RAMs, which are modelled inside the block as arrays. The arrays are not reset, so their contents survive a reset the way a battery would keep them.

The memory write is level-sensitive. While the chip-enable bit is set and the direction bit asks for a write, every clock cycle stores the data latch into the byte the address latches point at. Host software therefore has to set the data and address before it raises chip enable, and clear chip enable again after the write. If output enable is raised while the data port is still an output, the two sides would drive the same lines. The block does not model that short. It records the condition in a sticky flag.

Top module: `sram_cart_ppi`

## Requirements
- R1: The block reacts to a host access only while `iorq_n` is low and `addr[7:2]` equals `BASE[7:2]`. A write to any other port changes no register, and a read of any other port keeps `rd_en` low.
- R2: Register select `addr[1:0]` is 0 for the low-address latch, 1 for the high/strobe latch, 2 for the data latch and 3 for the control register. Host reads of select 0 and 1 return the latched bytes. `mem_addr[7:0]` follows the low latch, and `mem_addr[10:8]` follows bits 2:0 of the high latch.
- R3: Bits 5:3 of the high latch form the chip index. Bit 6 is chip enable. `mem_cs[i]` is high only when chip enable is set and the index equals i. Index values of 2 and above (byte address 0x1000 and up) select no chip: no byte is stored, and a read returns 0xFF.
- R4: A control write with bit 7 = 1 clears all three latches to 0. It sets the data port to input mode when bits 3 and 0 are both 1 (for example 0x89), and to output mode otherwise (for example 0x80). A control write with bit 7 = 0 has no effect. A read of select 3 returns 0xFF.
- R5: Bit 7 of the high latch selects output enable (1) or write enable (0). `mem_we` = enable AND NOT bit 7, and `mem_oe` = enable AND bit 7. On every clock edge where `mem_we` is high and a chip is selected, the data latch is stored at the current address of that chip.
- R6: While write enable and chip enable stay high, each change of the address latches stores the data latch at every intermediate address.
- R7: In input mode, a read of select 2 returns the addressed byte when output enable is active and a chip is selected, and 0xFF otherwise. In output mode it returns the data latch.
- R8: The edge after any cycle with `mem_oe` high while the data port is in output mode sets `contention`. The flag then stays set until reset.
- R9: Synchronous active-high reset clears the latches and the contention flag and selects output mode. The memory contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iorq_n | input | 1 | Host I/O request, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low, sampled on the clock |
| addr | input | 8 | Host I/O port address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data (0xFF when not driving) |
| rd_en | output | 1 | The block drives the host data bus |
| mem_addr | output | 11 | Address lines shared by both RAMs |
| mem_cs | output | 2 | Per-chip select |
| mem_we | output | 1 | RAM write enable |
| mem_oe | output | 1 | RAM output enable |
| contention | output | 1 | Sticky data-bus conflict flag |

## Verification
On every cycle the assertions check the following: the per-chip selects are never more than one-hot and never active without a strobe, write and output enable never overlap, host reads drive the bus only inside the decoded window, a mode-set write empties the strobes and address, and the conflict flag is set after an output-enable conflict and then holds. Other behaviour is visible only through the bench's scenarios, which write and then read memory back: the level-sensitive write-through of intermediate addresses, the keeping of two chips apart, the out-of-range chip index, the ignored control writes, and the retention of memory across reset.

// File: rtl/sram_cart_pkg.sv
package sram_cart_pkg;

    typedef enum logic [1:0] {
        SEL_ADDR_LO = 2'd0,
        SEL_ADDR_HI = 2'd1,
        SEL_DATA    = 2'd2,
        SEL_CTRL    = 2'd3
    } reg_sel_e;

    localparam int unsigned HI_ENABLE_BIT = 6;
    localparam int unsigned HI_READ_BIT   = 7;
    localparam int unsigned FULL_AW       = 14;
    localparam logic [7:0]  IDLE_BYTE     = 8'hFF;

    typedef struct packed {
        logic [7:0] lo;
        logic [7:0] hi;
        logic [7:0] data;
        logic       data_in;
    } latch_state_t;

    function automatic logic strobe_en(input latch_state_t s);
        return s.hi[HI_ENABLE_BIT];
    endfunction

    function automatic logic strobe_read(input latch_state_t s);
        return s.hi[HI_READ_BIT];
    endfunction

    function automatic logic [FULL_AW-1:0] full_address(input latch_state_t s);
        return {s.hi[5:0], s.lo};
    endfunction

endpackage

// File: rtl/cart_host_decode.sv
module cart_host_decode #(
    parameter logic [7:0] BASE = 8'hB0
) (
    input  logic        iorq_n,
    input  logic        rd_n,
    input  logic        wr_n,
    input  logic [7:0]  addr,
    output logic        wr_stb,
    output logic        rd_stb,
    output sram_cart_pkg::reg_sel_e sel
);
    logic hit;

    assign hit    = !iorq_n && (addr[7:2] == BASE[7:2]);
    assign wr_stb = hit && !wr_n;
    assign rd_stb = hit && !rd_n;
    assign sel    = sram_cart_pkg::reg_sel_e'(addr[1:0]);

endmodule

// File: rtl/cart_port_latches.sv
module cart_port_latches
    import sram_cart_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_stb,
    input  reg_sel_e     sel,
    input  logic [7:0]   wdata,
    output latch_state_t state
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '0;
        end else if (wr_stb) begin
            unique case (sel)
                SEL_ADDR_LO: state.lo   <= wdata;
                SEL_ADDR_HI: state.hi   <= wdata;
                SEL_DATA:    state.data <= wdata;
                SEL_CTRL: begin
                    if (wdata[7]) begin
                        state.lo      <= '0;
                        state.hi      <= '0;
                        state.data    <= '0;
                        state.data_in <= wdata[3] & wdata[0];
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cart_sram_bank.sv
module cart_sram_bank #(
    parameter int unsigned NUM_CHIPS  = 2,
    parameter int unsigned CHIP_BYTES = 2048,
    localparam int unsigned AW        = $clog2(CHIP_BYTES)
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [NUM_CHIPS-1:0] cs,
    input  logic [AW-1:0]        addr,
    input  logic [7:0]           wdata,
    output logic [7:0]           rdata
);
    logic [7:0] lane [NUM_CHIPS];

    for (genvar g = 0; g < NUM_CHIPS; g++) begin : g_chip
        logic [7:0] cells [CHIP_BYTES];

        always_ff @(posedge clk) begin
            if (we && cs[g]) begin
                cells[addr] <= wdata;
            end
        end

        assign lane[g] = cells[addr];
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CHIPS; i++) begin
            if (cs[i]) begin
                rdata = rdata | lane[i];
            end
        end
    end

endmodule

// File: rtl/sram_cart_ppi.sv
module sram_cart_ppi
    import sram_cart_pkg::*;
#(
    parameter logic [7:0]  BASE       = 8'hB0,
    parameter int unsigned NUM_CHIPS  = 2,
    parameter int unsigned CHIP_BYTES = 2048,
    localparam int unsigned AW        = $clog2(CHIP_BYTES),
    localparam int unsigned IDX_W     = FULL_AW - AW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 iorq_n,
    input  logic                 rd_n,
    input  logic                 wr_n,
    input  logic [7:0]           addr,
    input  logic [7:0]           wdata,
    output logic [7:0]           rdata,
    output logic                 rd_en,
    output logic [AW-1:0]        mem_addr,
    output logic [NUM_CHIPS-1:0] mem_cs,
    output logic                 mem_we,
    output logic                 mem_oe,
    output logic                 contention
);
    logic              wr_stb;
    reg_sel_e          sel;
    latch_state_t      st;
    logic [FULL_AW-1:0] full_a;
    logic [IDX_W-1:0]  chip_idx;
    logic [7:0]        mem_rdata;
    logic              portc_out;
    logic              enable;

    cart_host_decode #(.BASE(BASE)) u_decode (
        .iorq_n (iorq_n),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .addr   (addr),
        .wr_stb (wr_stb),
        .rd_stb (rd_en),
        .sel    (sel)
    );

    cart_port_latches u_latches (
        .clk    (clk),
        .rst    (rst),
        .wr_stb (wr_stb),
        .sel    (sel),
        .wdata  (wdata),
        .state  (st)
    );

    assign full_a    = full_address(st);
    assign mem_addr  = full_a[AW-1:0];
    assign chip_idx  = full_a[FULL_AW-1:AW];
    assign enable    = strobe_en(st);
    assign mem_we    = enable && !strobe_read(st);
    assign mem_oe    = enable && strobe_read(st);
    assign portc_out = !st.data_in;

    for (genvar g = 0; g < NUM_CHIPS; g++) begin : g_cs
        assign mem_cs[g] = enable && (chip_idx == IDX_W'(g));
    end

    cart_sram_bank #(
        .NUM_CHIPS  (NUM_CHIPS),
        .CHIP_BYTES (CHIP_BYTES)
    ) u_bank (
        .clk   (clk),
        .we    (mem_we),
        .cs    (mem_cs),
        .addr  (mem_addr),
        .wdata (st.data),
        .rdata (mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            contention <= 1'b0;
        end else if (mem_oe && portc_out) begin
            contention <= 1'b1;
        end
    end

    always_comb begin
        rdata = IDLE_BYTE;
        if (rd_en) begin
            unique case (sel)
                SEL_ADDR_LO: rdata = st.lo;
                SEL_ADDR_HI: rdata = st.hi;
                SEL_DATA: begin
                    if (portc_out)                rdata = st.data;
                    else if (mem_oe && |mem_cs)   rdata = mem_rdata;
                    else                          rdata = IDLE_BYTE;
                end
                default:     rdata = IDLE_BYTE;
            endcase
        end
    end

endmodule

// File: rtl/sram_cart_ppi_chk.sv
module sram_cart_ppi_chk #(
    parameter logic [7:0]  BASE      = 8'hB0,
    parameter int unsigned NUM_CHIPS = 2,
    parameter int unsigned AW        = 11
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 iorq_n,
    input logic                 wr_n,
    input logic [7:0]           addr,
    input logic [7:0]           wdata,
    input logic                 rd_en,
    input logic [AW-1:0]        mem_addr,
    input logic [NUM_CHIPS-1:0] mem_cs,
    input logic                 mem_we,
    input logic                 mem_oe,
    input logic                 portc_out,
    input logic                 contention
);
    logic ctrl_modeset;
    assign ctrl_modeset = !iorq_n && !wr_n && (addr == (BASE | 8'h03)) && wdata[7];

    AST_RD_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (!iorq_n && addr[7:2] == BASE[7:2])); // R1

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mem_cs)); // R3

    AST_CS_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        (|mem_cs) |-> (mem_we || mem_oe)); // R3

    AST_MODESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ctrl_modeset |=> (mem_addr == '0 && !mem_we && !mem_oe && mem_cs == '0)); // R4

    AST_WE_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_oe)); // R5

    AST_CONTENTION_SET: assert property (@(posedge clk) disable iff (rst)
        (mem_oe && portc_out) |=> contention); // R8

    AST_CONTENTION_STICKY: assert property (@(posedge clk) disable iff (rst)
        contention |=> contention); // R8

endmodule

bind sram_cart_ppi sram_cart_ppi_chk #(
    .BASE      (BASE),
    .NUM_CHIPS (NUM_CHIPS),
    .AW        (AW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .iorq_n     (iorq_n),
    .wr_n       (wr_n),
    .addr       (addr),
    .wdata      (wdata),
    .rd_en      (rd_en),
    .mem_addr   (mem_addr),
    .mem_cs     (mem_cs),
    .mem_we     (mem_we),
    .mem_oe     (mem_oe),
    .portc_out  (portc_out),
    .contention (contention)
);

// File: tb/sim_sram_cart_ppi.sv
module sim_sram_cart_ppi;
    localparam logic [7:0] BASE = 8'hB0;
    localparam logic [1:0] PA = 2'd0, PB = 2'd1, PC = 2'd2, PK = 2'd3;
    localparam int NV = 21;

    // {read, select, data or expected value, requirement number}
    localparam logic [14:0] VEC [NV] = '{
        {1'b0, PK, 8'h80, 4'd4},  // R4 output mode
        {1'b0, PC, 8'h5A, 4'd5},  // R5 data first
        {1'b0, PA, 8'h34, 4'd5},
        {1'b0, PB, 8'h41, 4'd5},  // R5 enable + write, 0x134
        {1'b0, PB, 8'h01, 4'd5},
        {1'b0, PC, 8'hC3, 4'd5},
        {1'b0, PA, 8'h35, 4'd5},
        {1'b0, PB, 8'h41, 4'd5},
        {1'b0, PB, 8'h01, 4'd5},
        {1'b0, PK, 8'h89, 4'd4},  // R4 input mode, latches cleared
        {1'b1, PA, 8'h00, 4'd4},  // R4 cleared latch
        {1'b0, PA, 8'h34, 4'd7},
        {1'b0, PB, 8'hC1, 4'd7},
        {1'b1, PC, 8'h5A, 4'd7},  // R7 byte at 0x134
        {1'b0, PA, 8'h35, 4'd7},
        {1'b1, PC, 8'hC3, 4'd7},  // R7 byte at 0x135
        {1'b0, PB, 8'h81, 4'd7},
        {1'b1, PC, 8'hFF, 4'd7},  // R7 enable off
        {1'b0, PK, 8'h09, 4'd4},  // R4 ignored control write
        {1'b1, PA, 8'h35, 4'd4},
        {1'b1, PB, 8'h81, 4'd2}   // R2 readback
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0]  addr = '0, wdata = '0;
    logic [7:0]  rdata;
    logic        rd_en;
    logic [10:0] mem_addr;
    logic [1:0]  mem_cs;
    logic        mem_we, mem_oe, contention;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sram_cart_ppi #(.BASE(BASE)) u0 (
        .clk(clk), .rst(rst), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rd_en(rd_en),
        .mem_addr(mem_addr), .mem_cs(mem_cs), .mem_we(mem_we),
        .mem_oe(mem_oe), .contention(contention)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic io_wr(input logic [7:0] port, input logic [7:0] d);
        @(negedge clk);
        iorq_n = 1'b0; wr_n = 1'b0; addr = port; wdata = d;
        @(negedge clk);
        iorq_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic io_rd(input logic [7:0] port, output logic [7:0] d, output logic en);
        @(negedge clk);
        iorq_n = 1'b0; rd_n = 1'b0; addr = port;
        #1;
        d = rdata; en = rd_en;
        @(negedge clk);
        iorq_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] s, input logic [7:0] exp);
        logic [7:0] d;
        logic en;
        io_rd(BASE | 8'(s), d, en);
        check(req, {7'd0, en, d}, {8'h01, exp});
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        io_wr(BASE | 8'(s), d);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic en;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R9 reset state
        check("R9 contention", {15'd0, contention}, 16'd0);
        check("R9 strobes", {14'd0, mem_we, mem_oe}, 16'd0);
        rd_chk("R9 lo latch", PA, 8'h00);
        rd_chk("R9 data latch (output mode)", PC, 8'h00);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][14]) begin
                rd_chk($sformatf("R%0d vector %0d", VEC[i][3:0], i), VEC[i][13:12], VEC[i][11:4]);
            end else begin
                wr(VEC[i][13:12], VEC[i][11:4]);
            end
            if (i == 3) begin
                #1;
                check("R5 write strobe", {13'd0, mem_we, mem_oe, mem_cs[0]}, 16'h0005);
            end
            if (i == 12) begin
                #1;
                check("R2 address pins", {5'd0, mem_addr}, 16'h0134);
                check("R3 chip0 selected", {14'd0, mem_cs}, 16'h0001);
            end
        end

        // R1 off-window accesses ignored
        io_wr(8'hB4, 8'h77);
        io_wr(8'hAF, 8'h66);
        rd_chk("R1 lo latch untouched", PA, 8'h35);
        io_rd(8'hB4, d, en);
        check("R1 no drive outside window", {15'd0, en}, 16'd0);
        check("R8 no conflict yet", {15'd0, contention}, 16'd0);

        // R6 level-sensitive write-through
        wr(PK, 8'h80);
        wr(PC, 8'hEE);
        wr(PA, 8'h10);
        wr(PB, 8'h40);
        wr(PA, 8'h11);
        wr(PA, 8'h12);
        wr(PB, 8'h00);
        wr(PK, 8'h89);
        wr(PB, 8'hC0);
        for (int a = 8'h10; a <= 8'h12; a++) begin
            wr(PA, 8'(a));
            rd_chk($sformatf("R6 intermediate 0x%0h", a), PC, 8'hEE);
        end

        // R3 second chip kept apart
        wr(PK, 8'h80);
        wr(PC, 8'h99);
        wr(PA, 8'h10);
        wr(PB, 8'h48);
        #1;
        check("R3 chip1 selected", {14'd0, mem_cs}, 16'h0002);
        wr(PB, 8'h08);
        // R3 out-of-range index 2 (0x1010)
        wr(PC, 8'h55);
        wr(PB, 8'h50);
        #1;
        check("R3 no chip for 0x1000+", {14'd0, mem_cs}, 16'h0000);
        wr(PB, 8'h10);
        wr(PK, 8'h89);
        wr(PA, 8'h10);
        wr(PB, 8'hC8);
        rd_chk("R3 chip1 byte", PC, 8'h99);
        wr(PB, 8'hC0);
        rd_chk("R3 chip0 byte unchanged", PC, 8'hEE);
        wr(PB, 8'hD0);
        rd_chk("R3 out of range reads idle", PC, 8'hFF);
        rd_chk("R4 control read", PK, 8'hFF);

        // R8 conflict detection
        wr(PK, 8'h80);
        wr(PB, 8'hC0);
        @(negedge clk);
        check("R8 conflict raised", {15'd0, contention}, 16'd1);
        wr(PB, 8'h00);
        wr(PK, 8'h89);
        @(negedge clk);
        check("R8 conflict sticky", {15'd0, contention}, 16'd1);

        // R9 reset keeps memory
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R9 flag cleared", {15'd0, contention}, 16'd0);
        rd_chk("R9 hi latch cleared", PB, 8'h00);
        wr(PK, 8'h89);
        wr(PA, 8'h11);
        wr(PB, 8'hC0);
        rd_chk("R9 memory retained", PC, 8'hEE);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule